// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This block resolves conditional branches for a small processor that splits the decision into two steps. A compare operation only records its two register operands in a latched pair. No flags are produced at that point. A later 16-bit branch word names one of ten relations. The block tests that relation between the first and the second latched operand, and it returns the next program counter together with a taken indication.

The branch outcome is registered. It appears one clock after the branch strobe and is held until the next recognised branch. A branch word that carries a condition code outside the defined set does not move the program counter. Instead, the block reports it as an illegal condition, so that the surrounding pipeline can vector to its exception handler.

Top module: `brc_unit`

## Requirements
- R1: After reset, next_pc_o, taken_o and illegal_o are 0 and both latched compare operands are 0.
- R2: When cmp_en_i is high, the operands cmp_a_i and cmp_b_i are stored unchanged at the clock edge. They are held until the next compare, and every later branch tests them.
- R3: When a compare and a branch arrive in the same cycle, the branch tests the operand pair held before that cycle. The new pair applies from the next branch onward.
- R4: A branch is accepted only when br_valid_i is high and insn_i[15:14] equals 2'b11. Any other word leaves next_pc_o, taken_o and illegal_o unchanged.
- R5: The condition code sits in insn_i[13:10]. The equality and unsigned codes are 0 for A==B, 1 for A!=B, 4 for A<B, 5 for A>B, 8 for A>=B and 9 for A<=B, where A is the first operand and B the second, both compared as unsigned.
- R6: The signed codes use two's complement. They are 2 for A<B, 3 for A>B, 6 for A>=B and 7 for A<=B.
- R7: A taken branch gives next_pc_o = pc_i + 2 + D. D is insn_i[9:0] sign-extended and multiplied by two. taken_o is 1 and illegal_o is 0.
- R8: A branch with a legal code whose relation is false gives next_pc_o = pc_i + 2, with taken_o = 0 and illegal_o = 0.
- R9: Condition codes 10 to 15 give illegal_o = 1, taken_o = 0 and next_pc_o = pc_i. The next legal branch clears illegal_o.
- R10: The outputs change only at the clock edge that samples an accepted branch. Without an accepted branch they hold, whatever pc_i does.
- R11: All program counter arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| pc_i | input | ADDR_W | Address of the branch word |
| insn_i | input | 16 | Branch word |
| cmp_en_i | input | 1 | Compare strobe: latch the operand pair |
| cmp_a_i | input | DATA_W | First compare operand |
| cmp_b_i | input | DATA_W | Second compare operand |
| br_valid_i | input | 1 | Branch strobe |
| next_pc_o | output | ADDR_W | Registered next program counter |
| taken_o | output | 1 | Registered branch-taken flag |
| illegal_o | output | 1 | Registered illegal-condition flag |

## Verification
The bench builds the unit with DATA_W = 6 and keeps ADDR_W at 32. With this setting, every one of the 4096 operand pairs can be driven through all sixteen condition codes. The sweep therefore reaches both sign boundaries, equal operands and the cases where the signed and unsigned orderings disagree. Keeping the full 32-bit program counter leaves address wrap in both directions and both displacement extremes within reach of directed cases.

// File: rtl/brc_pkg.sv
package brc_pkg;

  localparam int INSN_W  = 16;
  localparam int COND_W  = 4;
  localparam int COND_LO = 10;
  localparam int DISP_W  = 10;
  localparam int NUM_REL = 10;
  localparam int NUM_CODES = 1 << COND_W;

  // Condition codes; the numbering is decoded from the branch word.
  typedef enum logic [COND_W-1:0] {
    REL_EQ  = 4'd0,
    REL_NE  = 4'd1,
    REL_SLT = 4'd2,
    REL_SGT = 4'd3,
    REL_ULT = 4'd4,
    REL_UGT = 4'd5,
    REL_SGE = 4'd6,
    REL_SLE = 4'd7,
    REL_UGE = 4'd8,
    REL_ULE = 4'd9
  } rel_e;

  // Map the three primitive comparisons onto one relation.
  function automatic logic rel_select(input rel_e r, input logic eq,
                                      input logic ult, input logic slt);
    logic res;
    case (r)
      REL_EQ:  res = eq;
      REL_NE:  res = !eq;
      REL_SLT: res = slt;
      REL_SGT: res = !slt && !eq;
      REL_ULT: res = ult;
      REL_UGT: res = !ult && !eq;
      REL_SGE: res = !slt;
      REL_SLE: res = slt || eq;
      REL_UGE: res = !ult;
      REL_ULE: res = ult || eq;
      default: res = 1'b0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/brc_operand_latch.sv
module brc_operand_latch #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o
);

  logic [DATA_W-1:0] a_q, b_q, a_d, b_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (cap_i) begin
      a_d = a_i;
      b_d = b_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (cap_i) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign a_o = a_q;
  assign b_o = b_q;

  AST_OPND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> ($stable(a_o) && $stable(b_o))); // R2

  AST_OPND_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (a_o == $past(a_i) && b_o == $past(b_i))); // R2

endmodule

// File: rtl/brc_relation_eval.sv
module brc_relation_eval
  import brc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [COND_W-1:0] code_i,
  output logic              hit_o,
  output logic              bad_o
);

  logic eq, ult, slt;
  logic [NUM_CODES-1:0] rel_vec;

  assign eq  = (a_i == b_i);
  assign ult = (a_i < b_i);
  assign slt = ($signed(a_i) < $signed(b_i));

  // One result per code; codes past the defined set read as false.
  for (genvar k = 0; k < NUM_CODES; k++) begin : g_rel
    if (k < NUM_REL) begin : g_def
      assign rel_vec[k] = rel_select(rel_e'(k), eq, ult, slt);
    end else begin : g_undef
      assign rel_vec[k] = 1'b0;
    end
  end

  assign bad_o = (code_i >= COND_W'(NUM_REL));
  assign hit_o = rel_vec[code_i];

endmodule

// File: rtl/brc_target_calc.sv
module brc_target_calc #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 10
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [ADDR_W-1:0] seq_o,
  output logic [ADDR_W-1:0] tgt_o
);

  // Sign-extension width; ADDR_W must exceed DISP_W + 1.
  localparam int EXT_W = ADDR_W - DISP_W - 1;

  logic [ADDR_W-1:0] offset;

  assign offset = {{EXT_W{disp_i[DISP_W-1]}}, disp_i, 1'b0};
  assign seq_o  = pc_i + ADDR_W'(2);
  assign tgt_o  = seq_o + offset;

endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [15:0]       insn_i,
  input  logic              cmp_en_i,
  input  logic [DATA_W-1:0] cmp_a_i,
  input  logic [DATA_W-1:0] cmp_b_i,
  input  logic              br_valid_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              taken_o,
  output logic              illegal_o
);

  logic [DATA_W-1:0] opa, opb;
  logic [COND_W-1:0] code;
  logic              fire, hit, bad;
  logic [ADDR_W-1:0] seq_pc, tgt_pc;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              tk_q, tk_d, il_q, il_d;

  assign fire = br_valid_i && (insn_i[INSN_W-1 -: 2] == 2'b11);
  assign code = insn_i[COND_LO +: COND_W];

  brc_operand_latch #(.DATA_W(DATA_W)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_i (cmp_en_i),
    .a_i   (cmp_a_i),
    .b_i   (cmp_b_i),
    .a_o   (opa),
    .b_o   (opb)
  );

  brc_relation_eval #(.DATA_W(DATA_W)) u_eval (
    .a_i    (opa),
    .b_i    (opb),
    .code_i (code),
    .hit_o  (hit),
    .bad_o  (bad)
  );

  brc_target_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_tgt (
    .pc_i   (pc_i),
    .disp_i (insn_i[DISP_W-1:0]),
    .seq_o  (seq_pc),
    .tgt_o  (tgt_pc)
  );

  always_comb begin
    pc_d = pc_q;
    tk_d = tk_q;
    il_d = il_q;
    if (fire) begin
      if (bad) begin
        pc_d = pc_i;
        tk_d = 1'b0;
        il_d = 1'b1;
      end else begin
        pc_d = hit ? tgt_pc : seq_pc;
        tk_d = hit;
        il_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      tk_q <= 1'b0;
      il_q <= 1'b0;
    end else if (fire) begin
      pc_q <= pc_d;
      tk_q <= tk_d;
      il_q <= il_d;
    end
  end

  assign next_pc_o = pc_q;
  assign taken_o   = tk_q;
  assign illegal_o = il_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(br_valid_i && insn_i[15:14] == 2'b11) |=>
      ($stable(next_pc_o) && $stable(taken_o) && $stable(illegal_o))); // R10

  AST_BAD_CODE_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid_i && insn_i[15:14] == 2'b11 && insn_i[13:10] >= 4'd10) |=>
      (illegal_o && !taken_o && next_pc_o == $past(pc_i))); // R9

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid_i && insn_i[15:14] == 2'b11 && insn_i[13:10] < 4'd10) |=>
      (!illegal_o && (taken_o || next_pc_o == $past(pc_i) + ADDR_W'(2)))); // R8

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> !illegal_o); // R9

  AST_EQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && code == 4'd0 && opa == opb) |=> taken_o); // R5

endmodule

// File: tb/brc_unit_tb.sv
module brc_unit_tb;

  localparam int OPW = 6;
  localparam int AW  = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] pc;
  logic [15:0]   insn;
  logic          cmp_en;
  logic [OPW-1:0] ca, cb;
  logic          bv;
  logic [AW-1:0] next_pc;
  logic          taken, illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  brc_unit #(.ADDR_W(AW), .DATA_W(OPW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_i       (pc),
    .insn_i     (insn),
    .cmp_en_i   (cmp_en),
    .cmp_a_i    (ca),
    .cmp_b_i    (cb),
    .br_valid_i (bv),
    .next_pc_o  (next_pc),
    .taken_o    (taken),
    .illegal_o  (illegal)
  );

  function automatic logic [15:0] mk(input int code, input int disp);
    return {2'b11, 4'(code), 10'(disp)};
  endfunction

  function automatic bit exp_rel(input int code, input int a, input int b);
    int sa, sb;
    sa = (a >= (1 << (OPW-1))) ? a - (1 << OPW) : a;
    sb = (b >= (1 << (OPW-1))) ? b - (1 << OPW) : b;
    case (code)
      0: return a == b;
      1: return a != b;
      2: return sa < sb;
      3: return sa > sb;
      4: return a < b;
      5: return a > b;
      6: return sa >= sb;
      7: return sa <= sb;
      8: return a >= b;
      9: return a <= b;
      default: return 0;
    endcase
  endfunction

  function automatic logic [AW-1:0] exp_tgt(input logic [AW-1:0] p, input int disp);
    int d;
    d = (disp >= 512) ? disp - 1024 : disp;
    return p + 32'd2 + 32'(d * 2);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [AW-1:0] epc,
                     input logic et, input logic ei);
    checks++;
    if (next_pc !== epc || taken !== et || illegal !== ei) begin
      fails++;
      $display("FAIL %s: got pc=%h taken=%b illegal=%b, expected pc=%h taken=%b illegal=%b",
               req, next_pc, taken, illegal, epc, et, ei);
    end
  endtask

  task automatic idle();
    cmp_en = 0;
    bv     = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] p, e;
    rst_n = 0; pc = '0; insn = '0; cmp_en = 0; ca = '0; cb = '0; bv = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1 reset outputs", '0, 0, 0);

    // R1: compare registers reset to zero, so equal is taken
    pc = 32'h0000_0100; insn = mk(0, 4); bv = 1;
    step(); idle();
    chk("R1 zero operands", 32'h0000_010A, 1, 0);

    // R10: no accepted branch, pc changes, outputs hold
    pc = 32'hDEAD_BEE0;
    step(); step();
    chk("R10 hold when idle", 32'h0000_010A, 1, 0);

    // R4: non-branch words with the strobe are ignored
    bv = 1; insn = 16'h3C00; step();
    chk("R4 top bits 00", 32'h0000_010A, 1, 0);
    insn = 16'h8000; step();
    chk("R4 top bits 10", 32'h0000_010A, 1, 0);
    insn = 16'h4FFF; step(); idle();
    chk("R4 top bits 01", 32'h0000_010A, 1, 0);

    // R3: compare and branch together use the older pair
    cmp_en = 1; ca = 6'd5; cb = 6'd5; step();
    cmp_en = 1; ca = 6'd1; cb = 6'd2; bv = 1; pc = 32'h200; insn = mk(0, 3);
    step(); idle();
    chk("R3 same-cycle uses old pair", 32'h0000_0208, 1, 0);
    bv = 1; insn = mk(0, 3); step(); idle();
    chk("R2 new pair stored (eq false)", 32'h0000_0202, 0, 0);
    bv = 1; insn = mk(4, 3); step(); idle();
    chk("R2 new pair stored (ult true)", 32'h0000_0208, 1, 0);

    // R9: illegal code, then cleared by the next legal branch
    bv = 1; pc = 32'h0000_0400; insn = mk(12, 7); step(); idle();
    chk("R9 illegal code", 32'h0000_0400, 0, 1);
    bv = 1; insn = mk(1, 7); step(); idle();
    chk("R9 cleared by legal branch", 32'h0000_0410, 1, 0);

    // R11: wrap at both ends
    bv = 1; pc = 32'hFFFF_FFFE; insn = mk(0, 0); step(); idle();
    chk("R11 fall-through wrap", 32'h0000_0000, 0, 0);
    bv = 1; pc = 32'hFFFF_FFF0; insn = mk(1, 255); step(); idle();
    chk("R11 forward wrap", 32'h0000_01F0, 1, 0);
    bv = 1; pc = 32'h0000_0000; insn = mk(1, 512); step(); idle();
    chk("R11 backward wrap", 32'hFFFF_FC02, 1, 0);
    bv = 1; pc = 32'h0000_1000; insn = mk(1, 1023); step(); idle();
    chk("R7 displacement -1", 32'h0000_1000, 1, 0);

    // R5 R6 R7 R8 R9: sweep of every operand pair over every code
    for (int a = 0; a < (1 << OPW); a++) begin
      for (int b = 0; b < (1 << OPW); b++) begin
        cmp_en = 1; ca = OPW'(a); cb = OPW'(b); step(); idle();
        for (int c = 0; c < 16; c++) begin
          int dsp;
          bit t;
          dsp = (a * 37 + b * 11 + c * 67) & 1023;
          p = 32'h8000_0000 ^ (32'(a) << 22) ^ (32'(b) << 12) ^ (32'(c) << 2);
          bv = 1; pc = p; insn = mk(c, dsp);
          step(); idle();
          if (c >= 10) begin
            chk("R9 sweep illegal", p, 0, 1);
          end else begin
            t = exp_rel(c, a, b);
            e = t ? exp_tgt(p, dsp) : p + 32'd2;
            if (c == 2 || c == 3 || c == 6 || c == 7)
              chk(t ? "R6 R7 sweep signed" : "R6 R8 sweep signed", e, t, 0);
            else
              chk(t ? "R5 R7 sweep unsigned" : "R5 R8 sweep unsigned", e, t, 0);
          end
        end
      end
    end

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule